// File: doc/BRIEF.md
# USB Host Frame Timer

This block paces a USB host controller's schedule in frames. It holds an 11-bit frame number. While the controller runs, the number steps once per frame period. The period is a parameter counted in clock cycles: nominally 1 ms of the core clock, and much shorter in simulation. The block sends the frame number to the start-of-frame generator. It also issues a single-cycle strobe on each advance, so that the frame-list fetcher can begin the next frame.

The fetch address for the current frame-list entry comes from two parts. The upper 20 bits are a programmable base. The low ten bits of the frame number are placed beneath the base as a word index. Software sees three registers through a simple word-addressed write port with byte enables and a combinational read port:
- the frame number,
- the frame-list base,
- a five-bit interrupt enable set.

A write to the frame number is only honoured as a full 16-bit write while the controller is stopped and reports halted.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the frame number, interrupt enables and stored base are zero and `eof_o` is low.
- R2: While `run_i` stays high, the frame number rises by one every FRAME_CYCLES clock cycles. `eof_o` is high for exactly the one cycle in which the new number first appears.
- R3: The frame number wraps from 7FFh to 000h.
- R4: While `run_i` is low, the frame number does not advance and the period count restarts. After `run_i` rises, the first advance comes FRAME_CYCLES cycles later.
- R5: `fetch_addr_o` equals {stored base[31:12], frame number[9:0], 2'b00}.
- R6: A frame number write (reg_addr_i = 0) takes effect only when byte enables [1:0] are both set. It loads bits [10:0] of the write data. Any other enable pattern leaves the number unchanged.
- R7: A frame number write is ignored when `run_i` is high or `halted_i` is low.
- R8: Register index 0 reads the frame number in bits [10:0] with bits [31:11] zero. Index 3 reads all zero.
- R9: Register index 1 stores bits [31:12] under their own byte enables. Lane 1 writes bits [15:12], lane 2 writes bits [23:16] and lane 3 writes bits [31:24]. Bits [11:0] read as zero.
- R10: Register index 2 stores bits [4:0] when byte enable 0 is set and drives them on `irq_en_o`. The bits are: bit 0 timeout/CRC, bit 1 resume, bit 2 completion, bit 3 short packet, bit 4 scratch. Bits [31:5] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run/stop control: frames advance while high |
| halted_i | input | 1 | Controller halted status |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word index: 0 frame, 1 base, 2 interrupt enables |
| reg_be_i | input | 4 | Byte enables of the write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| frame_num_o | output | 11 | Current frame number for start-of-frame |
| fetch_addr_o | output | 32 | Address of the current frame-list entry |
| eof_o | output | 1 | One-cycle strobe on each frame advance |
| irq_en_o | output | 5 | Interrupt enable bits |

## Verification
The hardest situation to reach is the wrap from 7FFh to 000h. Reaching it naturally needs 2048 full frames. The bench instead halts the controller, loads 7FEh with a full-word write, and runs a short period across the boundary. Frame number writes succeed only in a narrow condition: index 0, both low lanes enabled, halted, and not running. The random stimulus therefore biases the byte enables toward all-ones and mostly ties `halted_i` to the inverse of `run_i`. This makes successful loads, rejected partial writes and rejected writes while running all occur many times.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int FRAME_W = 11;
  localparam int IDX_W   = 10;
  localparam int BASE_W  = 20;
  localparam int IEN_W   = 5;
  localparam int DATA_W  = 32;

  typedef enum logic [1:0] {
    RA_FRAME = 2'd0,
    RA_BASE  = 2'd1,
    RA_IEN   = 2'd2,
    RA_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/frm_tick.sv
module frm_tick #(
  parameter int FRAME_CYCLES = 48000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (FRAME_CYCLES > 2) ? $clog2(FRAME_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = run_i && (cnt_q == LAST);
    if (!run_i)
      cnt_d = '0;
    else if (tick_o)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/frm_counter.sv
module frm_counter
  import frm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_val_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               eof_o
);
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               frame_en;
  logic               eof_q;

  always_comb begin
    frame_en = tick_i || load_i;
    if (tick_i) frame_d = frame_q + 1'b1;
    else        frame_d = load_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame_q <= '0;
    else if (frame_en) frame_q <= frame_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eof_q <= 1'b0;
    else        eof_q <= tick_i;
  end

  assign frame_o = frame_q;
  assign eof_o   = eof_q;
endmodule

// File: rtl/frm_regs.sv
module frm_regs
  import frm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               halted_i,
  input  logic               wr_i,
  input  logic [1:0]         addr_i,
  input  logic [3:0]         be_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               frame_load_o,
  output logic [FRAME_W-1:0] frame_val_o,
  output logic [BASE_W-1:0]  base_o,
  output logic [IEN_W-1:0]   ien_o,
  output logic [DATA_W-1:0]  rdata_o
);
  reg_addr_e          sel;
  logic               base_wr, ien_wr;
  logic [BASE_W-1:0]  base_q;
  logic [IEN_W-1:0]   ien_q;

  always_comb begin
    sel          = reg_addr_e'(addr_i);
    frame_load_o = wr_i && (sel == RA_FRAME) && (be_i[1:0] == 2'b11)
                   && halted_i && !run_i;
    frame_val_o  = wdata_i[FRAME_W-1:0];
    base_wr      = wr_i && (sel == RA_BASE);
    ien_wr       = wr_i && (sel == RA_IEN) && be_i[0];
  end

  // lane 1 carries only bits [15:12] of the base
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  base_q[3:0] <= '0;
    else if (base_wr && be_i[1]) base_q[3:0] <= wdata_i[15:12];
  end

  for (genvar g = 2; g < 4; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  base_q[g*8-12 +: 8] <= '0;
      else if (base_wr && be_i[g]) base_q[g*8-12 +: 8] <= wdata_i[g*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_wr) ien_q <= wdata_i[IEN_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      RA_FRAME: rdata_o[FRAME_W-1:0]       = frame_i;
      RA_BASE:  rdata_o[DATA_W-1:12]       = base_q;
      RA_IEN:   rdata_o[IEN_W-1:0]         = ien_q;
      default:  rdata_o                    = '0;
    endcase
  end

  assign base_o = base_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import frm_pkg::*;
#(
  parameter int FRAME_CYCLES = 48000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_i,
  input  logic        halted_i,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [3:0]  reg_be_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic [10:0] frame_num_o,
  output logic [31:0] fetch_addr_o,
  output logic        eof_o,
  output logic [4:0]  irq_en_o
);
  logic               tick;
  logic               frame_load;
  logic [FRAME_W-1:0] frame_val;
  logic [FRAME_W-1:0] frame;
  logic [BASE_W-1:0]  base;

  frm_tick #(.FRAME_CYCLES(FRAME_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .tick_o(tick)
  );

  frm_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(frame_load),
    .load_val_i(frame_val), .frame_o(frame), .eof_o(eof_o)
  );

  frm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .halted_i(halted_i),
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .be_i(reg_be_i),
    .wdata_i(reg_wdata_i), .frame_i(frame), .frame_load_o(frame_load),
    .frame_val_o(frame_val), .base_o(base), .ien_o(irq_en_o),
    .rdata_o(reg_rdata_o)
  );

  assign frame_num_o  = frame;
  assign fetch_addr_o = {base, frame[IDX_W-1:0], 2'b00};
endmodule

// File: rtl/frm_chk.sv
module frm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_i,
  input logic [1:0]  reg_addr_i,
  input logic [31:0] reg_rdata_o,
  input logic [10:0] frame_num_o,
  input logic        eof_o
);
  // R2: each strobe coincides with a one-step advance
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> frame_num_o == 11'($past(frame_num_o) + 11'd1));

  // R2: the strobe lasts one cycle
  a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |=> !eof_o);

  // R4: no advance unless running at the previous edge
  a_r4_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_i) |-> !eof_o);

  // R7: while running, the number only moves with a strobe
  a_r7_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_i) && !eof_o |-> $stable(frame_num_o));

  // R8: reserved frame register bits read zero
  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr_i == 2'd0 |-> reg_rdata_o[31:11] == 21'd0);

  // R9: low base bits read zero
  a_r9_base_low: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr_i == 2'd1 |-> reg_rdata_o[11:0] == 12'd0);
endmodule

bind usb_frame_timer frm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .reg_addr_i(reg_addr_i),
  .reg_rdata_o(reg_rdata_o), .frame_num_o(frame_num_o), .eof_o(eof_o)
);

// File: tb/sim_usb_frame_timer.sv
`timescale 1ns/1ps
module sim_usb_frame_timer;
  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0, halted_i = 1'b1, reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [3:0]  reg_be_i = 4'd0;
  logic [31:0] reg_wdata_i = 32'd0;
  logic [31:0] reg_rdata_o, fetch_addr_o;
  logic [10:0] frame_num_o;
  logic        eof_o;
  logic [4:0]  irq_en_o;

  int errors = 0, checks = 0, cyc = 0;

  usb_frame_timer #(.FRAME_CYCLES(P)) u0 (.*);

  always #10 clk = ~clk;

  // reference state from the requirements
  logic [10:0] m_frame;
  logic [19:0] m_base;
  logic [4:0]  m_ien;
  logic        m_eof;
  int          m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_frame = 0; m_base = 0; m_ien = 0; m_eof = 0; m_cnt = 0;
    end else begin
      logic adv;
      adv   = run_i && (m_cnt == P-1);
      m_eof = adv;
      m_cnt = !run_i ? 0 : (adv ? 0 : m_cnt + 1);
      if (adv) m_frame = m_frame + 11'd1;
      else if (reg_wr_i && reg_addr_i == 0 && reg_be_i[1:0] == 2'b11
               && halted_i && !run_i)
        m_frame = reg_wdata_i[10:0];
      if (reg_wr_i && reg_addr_i == 1) begin
        if (reg_be_i[1]) m_base[3:0]   = reg_wdata_i[15:12];
        if (reg_be_i[2]) m_base[11:4]  = reg_wdata_i[23:16];
        if (reg_be_i[3]) m_base[19:12] = reg_wdata_i[31:24];
      end
      if (reg_wr_i && reg_addr_i == 2 && reg_be_i[0]) m_ien = reg_wdata_i[4:0];
    end
  end

  function automatic logic [31:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return {21'd0, m_frame};
      2'd1:    return {m_base, 12'd0};
      2'd2:    return {27'd0, m_ien};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 frame"}, {21'd0, frame_num_o}, {21'd0, m_frame});
    chk({tag, " R2 eof"}, {31'd0, eof_o}, {31'd0, m_eof});
    chk({tag, " R5 fetch"}, fetch_addr_o, {m_base, m_frame[9:0], 2'b00});
    chk({tag, " R8 rdata"}, reg_rdata_o, exp_rdata(reg_addr_i));
    chk({tag, " R10 ien"}, {27'd0, irq_en_o}, {27'd0, m_ien});
  endtask

  task automatic step(input string tag);
    @(posedge clk); @(negedge clk);
    check_all(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d, input string tag);
    reg_wr_i = 1; reg_addr_i = a; reg_be_i = be; reg_wdata_i = d;
    step(tag);
    reg_wr_i = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    chk("R1 base", fetch_addr_o, 32'd0);

    // R3 wrap via loaded value
    wr(2'd0, 4'hF, 32'h0000_07FE, "R6 load");
    chk("R6 loaded", {21'd0, frame_num_o}, 32'h7FE);
    run_i = 1; halted_i = 0;
    for (int i = 0; i < 3*P; i++) step("R3 wrap");
    chk("R3 wrapped", {21'd0, frame_num_o}, 32'h001);

    // R7 writes while running are ignored
    wr(2'd0, 4'hF, 32'h0000_0155, "R7 running");
    // R4 stop mid-period, restart
    for (int i = 0; i < 3; i++) step("R4 run");
    run_i = 0;
    for (int i = 0; i < 2*P; i++) step("R4 stopped");
    // R7 not halted yet stopped
    wr(2'd0, 4'hF, 32'h0000_0155, "R7 not halted");
    halted_i = 1;
    // R6 partial writes
    wr(2'd0, 4'b0001, 32'h0000_0222, "R6 partial lo");
    wr(2'd0, 4'b0010, 32'h0000_0333, "R6 partial hi");
    wr(2'd0, 4'b1100, 32'h0000_0444, "R6 upper lanes");
    // R9 base lanes and low bits
    wr(2'd1, 4'hF, 32'hFFFF_FFFF, "R9 base all");
    wr(2'd1, 4'b0100, 32'h0012_3456, "R9 base lane2");
    // R10 enables
    wr(2'd2, 4'b0001, 32'hFFFF_FFFF, "R10 ien");
    wr(2'd2, 4'b1110, 32'h0000_0000, "R10 ien no lane0");
    reg_addr_i = 2'd3; step("R8 idx3");
    run_i = 1; halted_i = 0;
    for (int i = 0; i < P+2; i++) step("R4 restart");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) run_i = ~run_i;
      halted_i = ($urandom_range(0, 7) == 0) ? 1'($urandom) : ~run_i;
      reg_wr_i    = ($urandom_range(0, 2) == 0);
      reg_addr_i  = 2'($urandom);
      reg_be_i    = ($urandom_range(0, 1) == 0) ? 4'hF : 4'($urandom);
      reg_wdata_i = $urandom;
      step("rand");
    end
    reg_wr_i = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule